// File: doc/BRIEF.md
# DMA Channel Configuration Register Bank with Lock and Commit

This block is the memory-mapped register bank of a single DMA channel. Software reaches it over a simple register bus (write strobe, read strobe, word address, 32-bit write data, 32-bit registered read data). The bank holds the channel's configuration: the mode word, the burst and transfer sizes, the address step values, the wrap sizes and steps, the shadow start addresses and an interface-control field. It drives each of these straight out to the transfer engine. The engine's live status (flags, remaining counts and working addresses) comes back in as read-only inputs, so software can read it at fixed word addresses.

Configuration is protected at two levels. A lock bit, once set, makes the whole set of configuration registers ignore bus writes. The control word and the count registers stay reachable. A separate commit bit is write-one-to-set and only reset clears it. Once commit is set, the lock bit can no longer be changed, so a locked configuration stays locked until the next reset. A write that is refused still completes on the bus without any error indication.

On every bus access the bank also records the security attributes presented with that access: processor ID, API link, link, zone, privilege ID, privilege level and secure flag. These are readable through two read-only words.

Top module: `chcfg_lock_regs`

## Requirements
- R1: After reset every configuration register reads 0, except the source wrap size (word 0x0A) and the destination wrap size (word 0x0D), which read 0x0000FFFF. The lock word (0x40), the commit word (0x41) and the command pulse output all read 0. Word address is byte offset divided by 4.
- R2: While unlocked, a write to a configuration word stores only its defined bits, and undefined bits read 0. The writable bits are:
  - mode (word 0x00): bits 21:17, 14:10 and 7:0, mask 0x003E7CFF;
  - burst size (word 0x02): bits 7:0;
  - step and size words: bits 15:0;
  - the four shadow address words (0x10, 0x11, 0x14, 0x15): all 32 bits;
  - interface control (word 0x28): bits 7:0.
- R3: While the lock bit is 1, a write to any configuration word leaves both its read value and its output port unchanged.
- R4: The lock never gates the control word (0x01). Writing it produces, on the cycle after the write, a one-cycle command pulse equal to the write data masked to bits 7, 4, 3, 2, 1 and 0 (mask 0x9F). At all other times the command pulse is 0.
- R5: The commit bit is bit 0 of word 0x41. Writing 1 sets it. Writing 0 never clears it; only reset does.
- R6: The lock bit can only change while commit is 0. Once commit reads 1, writes to word 0x40 leave the lock unchanged.
- R7: Any word address not listed here reads 0, and a write to it changes no register.
- R8: Each bus access (read or write) latches the accessor's attributes into two read-only words. A read returns the contents as they were before that same access.
  - Word 0x20 holds processor ID in bits 27:24, API link in 19:16, link in 11:8 and zone in 3:0.
  - Word 0x21 holds privilege ID in bits 23:16, privilege level in 9:8 and the secure flag in bit 0.
- R9: Read data is registered. It carries the addressed value in the cycle after the read strobe, and is 0 in a cycle that follows no read strobe.
- R10: Read-only status words come from the status inputs, and bus writes to them are ignored:
  - control word 0x01: status flags in bits 14:8;
  - burst count (0x03);
  - transfer count (0x07);
  - source wrap count (0x0B);
  - destination wrap count (0x0E);
  - active addresses at 0x12, 0x13, 0x16 and 0x17.
- R11: The lock word holds the lock in bit 0. A 1 there means locked, and the other bits of word 0x40 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| acc_cpu | input | 4 | Accessor processor ID |
| acc_api | input | 4 | Accessor API link |
| acc_link | input | 4 | Accessor link |
| acc_zone | input | 4 | Accessor zone |
| acc_priv_id | input | 8 | Accessor privilege ID |
| acc_priv_lvl | input | 2 | Accessor privilege level |
| acc_secure | input | 1 | Accessor secure flag |
| st_flags | input | 7 | Engine status flags, read at control bits 14:8 |
| st_burst_cnt | input | 8 | Remaining words in burst |
| st_xfer_cnt | input | 16 | Remaining bursts in transfer |
| st_src_wrap_cnt | input | 16 | Bursts before source wrap |
| st_dst_wrap_cnt | input | 16 | Bursts before destination wrap |
| st_src_beg | input | 32 | Active source begin address |
| st_src_cur | input | 32 | Active source address |
| st_dst_beg | input | 32 | Active destination begin address |
| st_dst_cur | input | 32 | Active destination address |
| cmd_pulse | output | 8 | One-cycle control command pulse |
| cfg_mode | output | 32 | Mode word |
| cfg_burst_size | output | 8 | Burst size |
| cfg_src_burst_step | output | 16 | Source step inside a burst |
| cfg_dst_burst_step | output | 16 | Destination step inside a burst |
| cfg_xfer_size | output | 16 | Transfer size |
| cfg_src_xfer_step | output | 16 | Source step per burst |
| cfg_dst_xfer_step | output | 16 | Destination step per burst |
| cfg_src_wrap_size | output | 16 | Source wrap size |
| cfg_src_wrap_step | output | 16 | Source wrap step |
| cfg_dst_wrap_size | output | 16 | Destination wrap size |
| cfg_dst_wrap_step | output | 16 | Destination wrap step |
| cfg_src_beg | output | 32 | Shadow source begin address |
| cfg_src_start | output | 32 | Shadow source address |
| cfg_dst_beg | output | 32 | Shadow destination begin address |
| cfg_dst_start | output | 32 | Shadow destination address |
| cfg_intf_ctrl | output | 8 | Interface control field |
| cfg_locked | output | 1 | Lock state |
| cfg_committed | output | 1 | Commit state |

## Verification
A lock flop that is wrong shows on the first refused or accepted configuration write. The read of that word one cycle later, and the matching cfg port directly after the write edge, keep or lose the old value. A commit that fails to stick shows as a lock that can be cleared again, visible at the next read of word 0x40. A decode or attribute fault shows in the very next read data: a misplaced field, a nonzero unlisted word, or an attribute value taken from the wrong access.

// File: rtl/chcfg_pkg.sv
// Package: word map, field masks and reset values of the channel bank.
// Assumes word addressing (byte offset / 4) and a 32-bit data path.
package chcfg_pkg;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 32;
    localparam int N_CFG  = 16;

    // Read-only and special word addresses
    localparam logic [ADDR_W-1:0] W_CTRL   = 7'h01;
    localparam logic [ADDR_W-1:0] W_BCNT   = 7'h03;
    localparam logic [ADDR_W-1:0] W_XCNT   = 7'h07;
    localparam logic [ADDR_W-1:0] W_SWCNT  = 7'h0B;
    localparam logic [ADDR_W-1:0] W_DWCNT  = 7'h0E;
    localparam logic [ADDR_W-1:0] W_SBEGA  = 7'h12;
    localparam logic [ADDR_W-1:0] W_SCURA  = 7'h13;
    localparam logic [ADDR_W-1:0] W_DBEGA  = 7'h16;
    localparam logic [ADDR_W-1:0] W_DCURA  = 7'h17;
    localparam logic [ADDR_W-1:0] W_ATTR1  = 7'h20;
    localparam logic [ADDR_W-1:0] W_ATTR2  = 7'h21;
    localparam logic [ADDR_W-1:0] W_LOCK   = 7'h40;
    localparam logic [ADDR_W-1:0] W_COMMIT = 7'h41;

    localparam logic [7:0] CMD_MASK = 8'h9F;

    // Configuration slot indices
    localparam int S_MODE = 0,  S_BURST = 1,  S_SBSTEP = 2,  S_DBSTEP = 3;
    localparam int S_XSIZE = 4, S_SXSTEP = 5, S_DXSTEP = 6,  S_SWSIZE = 7;
    localparam int S_SWSTEP = 8, S_DWSIZE = 9, S_DWSTEP = 10, S_SBEG = 11;
    localparam int S_SCUR = 12, S_DBEG = 13,  S_DCUR = 14,   S_INTF = 15;

    // Word address of each configuration slot
    function automatic logic [ADDR_W-1:0] cfg_word(input int s);
        case (s)
            S_MODE:   return 7'h00;
            S_BURST:  return 7'h02;
            S_SBSTEP: return 7'h04;
            S_DBSTEP: return 7'h05;
            S_XSIZE:  return 7'h06;
            S_SXSTEP: return 7'h08;
            S_DXSTEP: return 7'h09;
            S_SWSIZE: return 7'h0A;
            S_SWSTEP: return 7'h0C;
            S_DWSIZE: return 7'h0D;
            S_DWSTEP: return 7'h0F;
            S_SBEG:   return 7'h10;
            S_SCUR:   return 7'h11;
            S_DBEG:   return 7'h14;
            S_DCUR:   return 7'h15;
            default:  return 7'h28;
        endcase
    endfunction

    // Writable bit mask of each configuration slot
    function automatic logic [DATA_W-1:0] cfg_mask(input int s);
        case (s)
            S_MODE:                       return 32'h003E_7CFF;
            S_BURST, S_INTF:              return 32'h0000_00FF;
            S_SBEG, S_SCUR, S_DBEG, S_DCUR: return 32'hFFFF_FFFF;
            default:                      return 32'h0000_FFFF;
        endcase
    endfunction

    // Reset value of each configuration slot
    function automatic logic [DATA_W-1:0] cfg_reset(input int s);
        if (s == S_SWSIZE || s == S_DWSIZE) return 32'h0000_FFFF;
        return '0;
    endfunction
endpackage

// File: rtl/cfglk_decode.sv
// Address decoder: turns the word address into one-hot selects for the
// configuration slots and the control, lock and commit words.
// Assumes the slot map in chcfg_pkg has no duplicate addresses.
module cfglk_decode
    import chcfg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic [N_CFG-1:0]  cfg_hit,
    output logic              hit_ctrl,
    output logic              hit_lock,
    output logic              hit_commit
);
    // One comparator per configuration slot
    for (genvar i = 0; i < N_CFG; i++) begin : g_slot
        assign cfg_hit[i] = (addr == cfg_word(i));
    end

    assign hit_ctrl   = (addr == W_CTRL);
    assign hit_lock   = (addr == W_LOCK);
    assign hit_commit = (addr == W_COMMIT);

    // At most one target selected for any address
    always_comb begin
        p_single_hit_r7: assert ($onehot0({cfg_hit, hit_ctrl, hit_lock, hit_commit}));
    end
endmodule

// File: rtl/cfglk_guard.sv
// Lock and commit bits. Commit is write-one-to-set and sticky until reset;
// the lock bit follows bus writes only while commit is clear.
// Assumes a synchronous active-low reset.
module cfglk_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wbit,
    input  logic hit_lock,
    input  logic hit_commit,
    output logic lock_q,
    output logic commit_q
);
    // Lock bit: writable only before commit
    always_ff @(posedge clk) begin
        if (!rst_n)                          lock_q <= 1'b0;
        else if (wr && hit_lock && !commit_q) lock_q <= wbit;
    end

    // Commit bit: set by a write of 1, never cleared by the bus
    always_ff @(posedge clk) begin
        if (!rst_n)                        commit_q <= 1'b0;
        else if (wr && hit_commit && wbit) commit_q <= 1'b1;
    end

    p_commit_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |=> commit_q);
    p_lock_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |=> $stable(lock_q));
endmodule

// File: rtl/cfglk_store.sv
// Configuration register array. Each slot stores masked write data when
// selected and unlocked; reset loads the per-slot reset value.
// Assumes cfg_hit is one-hot or zero.
module cfglk_store
    import chcfg_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [N_CFG-1:0]              cfg_hit,
    input  logic                          locked,
    output logic [N_CFG-1:0][DATA_W-1:0]  cfg_q
);
    for (genvar i = 0; i < N_CFG; i++) begin : g_reg
        // Slot storage with lock gating and reserved-bit masking
        always_ff @(posedge clk) begin
            if (!rst_n)                          cfg_q[i] <= cfg_reset(i);
            else if (wr && cfg_hit[i] && !locked) cfg_q[i] <= wdata & cfg_mask(i);
        end

        p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            locked |=> $stable(cfg_q[i]));
    end
endmodule

// File: rtl/cfglk_attr.sv
// Security attribute capture: latches the accessor's identity fields on
// every bus access into two read-only words.
// Assumes attribute inputs are valid whenever a strobe is high.
module cfglk_attr (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        access,
    input  logic [3:0]  cpu,
    input  logic [3:0]  api,
    input  logic [3:0]  link,
    input  logic [3:0]  zone,
    input  logic [7:0]  priv_id,
    input  logic [1:0]  priv_lvl,
    input  logic        secure,
    output logic [31:0] attr1,
    output logic [31:0] attr2
);
    // Capture on any read or write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attr1 <= '0;
            attr2 <= '0;
        end else if (access) begin
            attr1 <= {4'h0, cpu, 4'h0, api, 4'h0, link, 4'h0, zone};
            attr2 <= {8'h00, priv_id, 6'h00, priv_lvl, 7'h00, secure};
        end
    end

    p_attr_zone_r8: assert property (@(posedge clk) disable iff (!rst_n)
        access |=> attr1[3:0] == $past(zone));
    p_attr_secure_r8: assert property (@(posedge clk) disable iff (!rst_n)
        access |=> attr2[0] == $past(secure));
endmodule

// File: rtl/chcfg_lock_regs.sv
// Top of the DMA channel configuration bank: decode, lock/commit guard,
// configuration store, attribute capture, control command pulse and a
// registered read mux. Assumes single-cycle bus strobes, synchronous reset.
module chcfg_lock_regs
    import chcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [6:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [3:0]        acc_cpu,
    input  logic [3:0]        acc_api,
    input  logic [3:0]        acc_link,
    input  logic [3:0]        acc_zone,
    input  logic [7:0]        acc_priv_id,
    input  logic [1:0]        acc_priv_lvl,
    input  logic              acc_secure,
    input  logic [6:0]        st_flags,
    input  logic [7:0]        st_burst_cnt,
    input  logic [15:0]       st_xfer_cnt,
    input  logic [15:0]       st_src_wrap_cnt,
    input  logic [15:0]       st_dst_wrap_cnt,
    input  logic [31:0]       st_src_beg,
    input  logic [31:0]       st_src_cur,
    input  logic [31:0]       st_dst_beg,
    input  logic [31:0]       st_dst_cur,
    output logic [7:0]        cmd_pulse,
    output logic [31:0]       cfg_mode,
    output logic [7:0]        cfg_burst_size,
    output logic [15:0]       cfg_src_burst_step,
    output logic [15:0]       cfg_dst_burst_step,
    output logic [15:0]       cfg_xfer_size,
    output logic [15:0]       cfg_src_xfer_step,
    output logic [15:0]       cfg_dst_xfer_step,
    output logic [15:0]       cfg_src_wrap_size,
    output logic [15:0]       cfg_src_wrap_step,
    output logic [15:0]       cfg_dst_wrap_size,
    output logic [15:0]       cfg_dst_wrap_step,
    output logic [31:0]       cfg_src_beg,
    output logic [31:0]       cfg_src_start,
    output logic [31:0]       cfg_dst_beg,
    output logic [31:0]       cfg_dst_start,
    output logic [7:0]        cfg_intf_ctrl,
    output logic              cfg_locked,
    output logic              cfg_committed
);
    logic [N_CFG-1:0]              cfg_hit;
    logic                          hit_ctrl, hit_lock, hit_commit;
    logic                          lock_q, commit_q;
    logic [N_CFG-1:0][DATA_W-1:0]  cfg_q;
    logic [DATA_W-1:0]             attr1, attr2;
    logic [DATA_W-1:0]             rd_val;

    cfglk_decode u_dec (
        .addr       (bus_addr),
        .cfg_hit    (cfg_hit),
        .hit_ctrl   (hit_ctrl),
        .hit_lock   (hit_lock),
        .hit_commit (hit_commit)
    );

    cfglk_guard u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (bus_wr),
        .wbit       (bus_wdata[0]),
        .hit_lock   (hit_lock),
        .hit_commit (hit_commit),
        .lock_q     (lock_q),
        .commit_q   (commit_q)
    );

    cfglk_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .wdata   (bus_wdata),
        .cfg_hit (cfg_hit),
        .locked  (lock_q),
        .cfg_q   (cfg_q)
    );

    cfglk_attr u_attr (
        .clk      (clk),
        .rst_n    (rst_n),
        .access   (bus_wr | bus_rd),
        .cpu      (acc_cpu),
        .api      (acc_api),
        .link     (acc_link),
        .zone     (acc_zone),
        .priv_id  (acc_priv_id),
        .priv_lvl (acc_priv_lvl),
        .secure   (acc_secure),
        .attr1    (attr1),
        .attr2    (attr2)
    );

    // Control command pulse: one cycle, never gated by the lock
    always_ff @(posedge clk) begin
        if (!rst_n)                cmd_pulse <= '0;
        else if (bus_wr && hit_ctrl) cmd_pulse <= bus_wdata[7:0] & CMD_MASK;
        else                       cmd_pulse <= '0;
    end

    // Read mux: configuration slots, then read-only words, else zero
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < N_CFG; i++) begin
            if (cfg_hit[i]) rd_val = cfg_q[i];
        end
        case (bus_addr)
            W_CTRL:   rd_val = {17'h0, st_flags, 8'h00};
            W_BCNT:   rd_val = {24'h0, st_burst_cnt};
            W_XCNT:   rd_val = {16'h0, st_xfer_cnt};
            W_SWCNT:  rd_val = {16'h0, st_src_wrap_cnt};
            W_DWCNT:  rd_val = {16'h0, st_dst_wrap_cnt};
            W_SBEGA:  rd_val = st_src_beg;
            W_SCURA:  rd_val = st_src_cur;
            W_DBEGA:  rd_val = st_dst_beg;
            W_DCURA:  rd_val = st_dst_cur;
            W_ATTR1:  rd_val = attr1;
            W_ATTR2:  rd_val = attr2;
            W_LOCK:   rd_val = {31'h0, lock_q};
            W_COMMIT: rd_val = {31'h0, commit_q};
            default:  ;
        endcase
    end

    // Registered read data, zero when no read
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
        else             bus_rdata <= '0;
    end

    assign cfg_mode           = cfg_q[S_MODE];
    assign cfg_burst_size     = cfg_q[S_BURST][7:0];
    assign cfg_src_burst_step = cfg_q[S_SBSTEP][15:0];
    assign cfg_dst_burst_step = cfg_q[S_DBSTEP][15:0];
    assign cfg_xfer_size      = cfg_q[S_XSIZE][15:0];
    assign cfg_src_xfer_step  = cfg_q[S_SXSTEP][15:0];
    assign cfg_dst_xfer_step  = cfg_q[S_DXSTEP][15:0];
    assign cfg_src_wrap_size  = cfg_q[S_SWSIZE][15:0];
    assign cfg_src_wrap_step  = cfg_q[S_SWSTEP][15:0];
    assign cfg_dst_wrap_size  = cfg_q[S_DWSIZE][15:0];
    assign cfg_dst_wrap_step  = cfg_q[S_DWSTEP][15:0];
    assign cfg_src_beg        = cfg_q[S_SBEG];
    assign cfg_src_start      = cfg_q[S_SCUR];
    assign cfg_dst_beg        = cfg_q[S_DBEG];
    assign cfg_dst_start      = cfg_q[S_DCUR];
    assign cfg_intf_ctrl      = cfg_q[S_INTF][7:0];
    assign cfg_locked         = lock_q;
    assign cfg_committed      = commit_q;

    p_cmd_from_ctrl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pulse != 8'h00) |-> $past(bus_wr && hit_ctrl));
    p_cmd_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pulse & ~CMD_MASK) == 8'h00);
    p_rdata_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == 32'h0);
endmodule

// File: tb/sim_chcfg_lock_regs.sv
module sim_chcfg_lock_regs;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [6:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0] acc_cpu = '0, acc_api = '0, acc_link = '0, acc_zone = '0;
    logic [7:0] acc_priv_id = '0;
    logic [1:0] acc_priv_lvl = '0;
    logic acc_secure = 1'b0;
    logic [6:0] st_flags = '0;
    logic [7:0] st_burst_cnt = '0;
    logic [15:0] st_xfer_cnt = '0, st_src_wrap_cnt = '0, st_dst_wrap_cnt = '0;
    logic [31:0] st_src_beg = '0, st_src_cur = '0, st_dst_beg = '0, st_dst_cur = '0;
    logic [7:0] cmd_pulse;
    logic [31:0] cfg_mode, cfg_src_beg, cfg_src_start, cfg_dst_beg, cfg_dst_start;
    logic [7:0] cfg_burst_size, cfg_intf_ctrl;
    logic [15:0] cfg_src_burst_step, cfg_dst_burst_step, cfg_xfer_size;
    logic [15:0] cfg_src_xfer_step, cfg_dst_xfer_step, cfg_src_wrap_size;
    logic [15:0] cfg_src_wrap_step, cfg_dst_wrap_size, cfg_dst_wrap_step;
    logic cfg_locked, cfg_committed;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chcfg_lock_regs u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_read(7'h00, v); chk("R1 mode reset", v, 32'h0);
        bus_read(7'h0A, v); chk("R1 src wrap size reset", v, 32'h0000FFFF);
        bus_read(7'h0D, v); chk("R1 dst wrap size reset", v, 32'h0000FFFF);
        bus_read(7'h40, v); chk("R1 lock reset", v, 32'h0);
        bus_read(7'h41, v); chk("R1 commit reset", v, 32'h0);
        chk("R1 cmd pulse reset", {24'h0, cmd_pulse}, 32'h0);
        chk("R1 dst wrap port", {16'h0, cfg_dst_wrap_size}, 32'h0000FFFF);
    endtask

    task automatic t_masked_write();
        logic [31:0] v;
        bus_write(7'h00, 32'hFFFF_FFFF);
        bus_read(7'h00, v); chk("R2 mode mask", v, 32'h003E7CFF);
        bus_write(7'h02, 32'h0000_1234);
        bus_read(7'h02, v); chk("R2 burst size mask", v, 32'h34);
        bus_write(7'h10, 32'hDEAD_BEEF);
        bus_read(7'h10, v); chk("R2 src begin full word", v, 32'hDEADBEEF);
        chk("R2 src begin port", cfg_src_beg, 32'hDEADBEEF);
        bus_write(7'h04, 32'hABCD_F001);
        chk("R2 step port", {16'h0, cfg_src_burst_step}, 32'h0000F001);
        // R9: idle cycle after the read above gives zero data
        bus_read(7'h04, v); chk("R2 step read", v, 32'h0000F001);
        @(negedge clk); chk("R9 rdata idle zero", bus_rdata, 32'h0);
    endtask

    task automatic t_unlisted();
        logic [31:0] v;
        bus_write(7'h18, 32'h5555_5555);
        bus_read(7'h18, v); chk("R7 unlisted reads zero", v, 32'h0);
        bus_write(7'h7F, 32'hFFFF_FFFF);
        bus_read(7'h7F, v); chk("R7 unlisted top reads zero", v, 32'h0);
        bus_read(7'h00, v); chk("R7 mode untouched", v, 32'h003E7CFF);
    endtask

    task automatic t_status();
        logic [31:0] v;
        st_flags = 7'h5A; st_xfer_cnt = 16'h0123; st_dst_cur = 32'h8000_0044;
        st_burst_cnt = 8'h1F;
        bus_read(7'h01, v); chk("R10 control flags", v, 32'h00005A00);
        bus_read(7'h07, v); chk("R10 transfer count", v, 32'h00000123);
        bus_read(7'h17, v); chk("R10 dst active", v, 32'h80000044);
        bus_write(7'h03, 32'hFFFF_FFFF);
        bus_read(7'h03, v); chk("R10 burst count write ignored", v, 32'h0000001F);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        bus_write(7'h40, 32'hFFFF_FFFF);
        bus_read(7'h40, v); chk("R11 lock only bit0", v, 32'h1);
        chk("R11 lock port", {31'h0, cfg_locked}, 32'h1);
        bus_write(7'h00, 32'h0);
        chk("R3 mode port held", cfg_mode, 32'h003E7CFF);
        bus_read(7'h00, v); chk("R3 mode held", v, 32'h003E7CFF);
        bus_write(7'h10, 32'h1111_2222);
        bus_read(7'h10, v); chk("R3 src begin held", v, 32'hDEADBEEF);
    endtask

    task automatic t_ctrl();
        bus_write(7'h01, 32'h0000_00FF);
        chk("R4 cmd pulse while locked", {24'h0, cmd_pulse}, 32'h9F);
        @(negedge clk);
        chk("R4 cmd pulse one cycle", {24'h0, cmd_pulse}, 32'h0);
    endtask

    task automatic t_unlock();
        logic [31:0] v;
        bus_write(7'h40, 32'h0);
        bus_read(7'h40, v); chk("R11 unlock", v, 32'h0);
        bus_write(7'h00, 32'h0000_0005);
        bus_read(7'h00, v); chk("R2 mode after unlock", v, 32'h5);
    endtask

    task automatic t_attr();
        logic [31:0] v;
        acc_cpu = 4'h3; acc_api = 4'hA; acc_link = 4'h6; acc_zone = 4'h9;
        acc_priv_id = 8'hC4; acc_priv_lvl = 2'd2; acc_secure = 1'b1;
        bus_write(7'h18, 32'h0);
        acc_cpu = 4'h1; acc_api = 4'h2; acc_link = 4'h4; acc_zone = 4'h8;
        acc_priv_id = 8'h37; acc_priv_lvl = 2'd1; acc_secure = 1'b0;
        bus_read(7'h20, v); chk("R8 attr1 from previous access", v, 32'h030A0609);
        bus_read(7'h21, v); chk("R8 attr2 from previous access", v, 32'h00370100);
        acc_cpu = 4'h0; acc_api = 4'h0; acc_link = 4'h0; acc_zone = 4'h0;
        bus_read(7'h20, v); chk("R8 attr1 latched by read", v, 32'h01020408);
    endtask

    task automatic t_commit();
        logic [31:0] v;
        bus_write(7'h40, 32'h1);
        bus_write(7'h41, 32'h1);
        chk("R5 commit port", {31'h0, cfg_committed}, 32'h1);
        bus_write(7'h41, 32'h0);
        bus_read(7'h41, v); chk("R5 commit sticky", v, 32'h1);
        bus_write(7'h40, 32'h0);
        bus_read(7'h40, v); chk("R6 lock frozen", v, 32'h1);
        bus_write(7'h00, 32'h0000_0400);
        bus_read(7'h00, v); chk("R6 mode still protected", v, 32'h5);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_masked_write();
        t_unlisted();
        t_status();
        t_lock();
        t_ctrl();
        t_unlock();
        t_attr();
        t_commit();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end
endmodule